// File: doc/BRIEF.md
# Video DAC Input Source Selector

This block sits in front of the digital inputs of a palette DAC and decides, for each of three signal groups, whether the on-board video controller or an external adapter card supplies them. The groups are the sync-and-blank trio, the 8-bit pixel address, and the dot clock. Each group has its own active-low takeover enable, which reads as "controller" when left high. The selected pixel address is captured into a DAC-side latch whenever the selected dot-clock source pulses. While blanking is asserted the colour index presented to the DAC is forced to zero.

Both dot-clock sources are carried as single-cycle strobes in one system clock domain, so the whole block is synchronous. Each takeover enable passes through a two-flop synchroniser before it steers any selector. The block also watches the configuration: the controller's 3-bit clock-select code must equal 3'b010 exactly when the external clock is in use, and an external clock is only legal together with external pixel data. Either violation sets a sticky error flag, which a write-one-to-clear pulse resets.

Top module: `vdac_src_sel`

## Requirements
- R1: When the synchronised sync enable is high, outHsync, outVsync and outBlankN follow the controller inputs; when it is low they follow the adapter inputs.
- R2: When the synchronised pixel enable is high, the latch captures ctlPixel; when it is low, the latch captures adpPixel.
- R3: When the synchronised clock enable is high, ctlDotStb is the capture strobe and is forwarded on adpClkOut; when it is low, adpDotStb is the capture strobe and adpClkOut is held at 0. A strobe from the unselected source does not change the latch. dotStbOut shows the selected strobe.
- R4: The latch loads at the clock edge where the selected strobe is 1 and holds its value at every other edge.
- R5: While outBlankN is 0, dacColor is 8'h00. The latch still loads during blanking, and its value shows again once outBlankN returns to 1.
- R6: cfgErr is set one edge after the clock-select code equal to 3'b010 disagrees with the synchronised external-clock state (code 3'b010 with internal clock, or any other code with external clock).
- R7: cfgErr is set one edge after the external clock is selected while the synchronised pixel enable is high.
- R8: cfgErr is sticky. It clears at an edge where errClear is 1 and no error condition is present. If an error condition and errClear occur in the same cycle, the set wins.
- R9: A change on a takeover enable steers its selector only after two clock edges. Reset leaves all enables reading high, the latch at 0 and cfgErr at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| takeSyncN | input | 1 | Adapter takes sync/blank when low (async) |
| takePixN | input | 1 | Adapter takes pixel address when low (async) |
| takeClkN | input | 1 | Adapter takes dot clock when low (async) |
| clkSelCode | input | 3 | Controller clock-select code |
| errClear | input | 1 | Write-one-to-clear for cfgErr |
| ctlHsync | input | 1 | Controller horizontal sync |
| ctlVsync | input | 1 | Controller vertical sync |
| ctlBlankN | input | 1 | Controller blank, active low |
| ctlPixel | input | 8 | Controller pixel address |
| ctlDotStb | input | 1 | Controller dot-clock strobe |
| adpHsync | input | 1 | Adapter horizontal sync |
| adpVsync | input | 1 | Adapter vertical sync |
| adpBlankN | input | 1 | Adapter blank, active low |
| adpPixel | input | 8 | Adapter pixel address |
| adpDotStb | input | 1 | Adapter dot-clock strobe |
| outHsync | output | 1 | Selected horizontal sync |
| outVsync | output | 1 | Selected vertical sync |
| outBlankN | output | 1 | Selected blank, active low |
| dacColor | output | 8 | Latched pixel address, zero while blanked |
| dotStbOut | output | 1 | Selected dot-clock strobe |
| adpClkOut | output | 1 | Controller dot strobe forwarded to adapter |
| cfgErr | output | 1 | Sticky configuration error |

## Verification
Two pairs of functions can fall in the same cycle. In the first, an error condition and the clear pulse arrive together. The bench provokes this by holding errClear high while a clock-select code mismatch is present, and expects cfgErr to stay set; cfgErr must drop only after the code is corrected. In the second, a pixel capture lands during blanking. The bench strobes a new adapter pixel while adapter blank is low, expects zero at dacColor, and expects the new value to appear once blank is released.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic useAdpSync;
    logic useAdpPix;
    logic useAdpClk;
    logic capture;
    logic errSet;
  } selStrb_t;

  localparam int GROUPS = 3;
endpackage

// File: rtl/vdac_ctrl.sv
module vdac_ctrl
  import vdac_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] EXT_CODE = 3'b010,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             takeSyncN,
  input  logic             takePixN,
  input  logic             takeClkN,
  input  logic [SEL_W-1:0] clkSelCode,
  input  logic             errClear,
  input  logic             ctlDotStb,
  input  logic             adpDotStb,
  output selStrb_t         strb,
  output logic             dotStbOut,
  output logic             adpClkOut,
  output logic             cfgErr
);
  logic [GROUPS-1:0] rawN;
  logic [GROUPS-1:0] syncN;

  assign rawN = {takeClkN, takePixN, takeSyncN};

  // Each enable is resynchronised; reset value models the pull-up
  for (genvar g = 0; g < GROUPS; g++) begin : gSync
    logic [SYNC_STAGES-1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= '1;
      else       stage <= {stage[SYNC_STAGES-2:0], rawN[g]};
    end
    assign syncN[g] = stage[SYNC_STAGES-1];
  end

  logic useAdpClk, useAdpPix, useAdpSync;
  logic codeIsExt, clkMismatch, dataMismatch, selStb;

  assign useAdpSync = ~syncN[0];
  assign useAdpPix  = ~syncN[1];
  assign useAdpClk  = ~syncN[2];

  assign codeIsExt    = (clkSelCode == EXT_CODE);
  assign clkMismatch  = codeIsExt ^ useAdpClk;
  assign dataMismatch = useAdpClk & ~useAdpPix;

  assign selStb    = useAdpClk ? adpDotStb : ctlDotStb;
  assign dotStbOut = selStb;
  assign adpClkOut = ~useAdpClk & ctlDotStb;

  always_comb begin
    strb.useAdpSync = useAdpSync;
    strb.useAdpPix  = useAdpPix;
    strb.useAdpClk  = useAdpClk;
    strb.capture    = selStb;
    strb.errSet     = clkMismatch | dataMismatch;
  end

  // Sticky flag, set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgErr <= 1'b0;
    else if (strb.errSet)  cfgErr <= 1'b1;
    else if (errClear)     cfgErr <= 1'b0;
  end
endmodule

// File: rtl/vdac_dpath.sv
module vdac_dpath
  import vdac_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  selStrb_t         strb,
  input  logic             ctlHsync,
  input  logic             ctlVsync,
  input  logic             ctlBlankN,
  input  logic [PIX_W-1:0] ctlPixel,
  input  logic             adpHsync,
  input  logic             adpVsync,
  input  logic             adpBlankN,
  input  logic [PIX_W-1:0] adpPixel,
  output logic             outHsync,
  output logic             outVsync,
  output logic             outBlankN,
  output logic [PIX_W-1:0] dacColor,
  output logic [PIX_W-1:0] latchQ
);
  logic [PIX_W-1:0] selPixel;

  always_comb begin
    if (strb.useAdpSync) begin
      outHsync  = adpHsync;
      outVsync  = adpVsync;
      outBlankN = adpBlankN;
    end else begin
      outHsync  = ctlHsync;
      outVsync  = ctlVsync;
      outBlankN = ctlBlankN;
    end
  end

  assign selPixel = strb.useAdpPix ? adpPixel : ctlPixel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchQ <= '0;
    else if (strb.capture) latchQ <= selPixel;
  end

  assign dacColor = outBlankN ? latchQ : '0;
endmodule

// File: rtl/vdac_src_sel.sv
module vdac_src_sel
  import vdac_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] EXT_CODE = 3'b010,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             takeSyncN,
  input  logic             takePixN,
  input  logic             takeClkN,
  input  logic [SEL_W-1:0] clkSelCode,
  input  logic             errClear,
  input  logic             ctlHsync,
  input  logic             ctlVsync,
  input  logic             ctlBlankN,
  input  logic [PIX_W-1:0] ctlPixel,
  input  logic             ctlDotStb,
  input  logic             adpHsync,
  input  logic             adpVsync,
  input  logic             adpBlankN,
  input  logic [PIX_W-1:0] adpPixel,
  input  logic             adpDotStb,
  output logic             outHsync,
  output logic             outVsync,
  output logic             outBlankN,
  output logic [PIX_W-1:0] dacColor,
  output logic             dotStbOut,
  output logic             adpClkOut,
  output logic             cfgErr
);
  selStrb_t         strb;
  logic [PIX_W-1:0] latchQ;
  logic             errSetW;
  logic             useAdpClkW;

  assign errSetW    = strb.errSet;
  assign useAdpClkW = strb.useAdpClk;

  vdac_ctrl #(.SEL_W(SEL_W), .EXT_CODE(EXT_CODE), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .takeSyncN(takeSyncN), .takePixN(takePixN), .takeClkN(takeClkN),
    .clkSelCode(clkSelCode), .errClear(errClear),
    .ctlDotStb(ctlDotStb), .adpDotStb(adpDotStb),
    .strb(strb), .dotStbOut(dotStbOut), .adpClkOut(adpClkOut), .cfgErr(cfgErr)
  );

  vdac_dpath #(.PIX_W(PIX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ctlHsync(ctlHsync), .ctlVsync(ctlVsync), .ctlBlankN(ctlBlankN), .ctlPixel(ctlPixel),
    .adpHsync(adpHsync), .adpVsync(adpVsync), .adpBlankN(adpBlankN), .adpPixel(adpPixel),
    .outHsync(outHsync), .outVsync(outVsync), .outBlankN(outBlankN),
    .dacColor(dacColor), .latchQ(latchQ)
  );
endmodule

// File: rtl/vdac_src_sel_chk.sv
module vdac_src_sel_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             outBlankN,
  input logic [PIX_W-1:0] dacColor,
  input logic             dotStbOut,
  input logic [PIX_W-1:0] latchQ,
  input logic             cfgErr,
  input logic             errClear,
  input logic             errSetW,
  input logic             useAdpClkW,
  input logic             adpClkOut,
  input logic             ctlDotStb
);
  assert_blank_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !outBlankN |-> (dacColor == '0));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !dotStbOut |=> $stable(latchQ));

  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    errSetW |=> cfgErr);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !errClear) |=> cfgErr);

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errClear && !errSetW) |=> !cfgErr);

  assert_ext_clk_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    useAdpClkW |-> !adpClkOut);

  assert_int_clk_fwd_R3: assert property (@(posedge clk) disable iff (!rstN)
    !useAdpClkW |-> (adpClkOut == ctlDotStb));
endmodule

bind vdac_src_sel vdac_src_sel_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .outBlankN(outBlankN), .dacColor(dacColor),
  .dotStbOut(dotStbOut), .latchQ(latchQ), .cfgErr(cfgErr), .errClear(errClear),
  .errSetW(errSetW), .useAdpClkW(useAdpClkW), .adpClkOut(adpClkOut),
  .ctlDotStb(ctlDotStb)
);

// File: tb/vdac_src_sel_tb.sv
`timescale 1ns/1ps
module vdac_src_sel_tb;
  localparam int SIG_HS = 0, SIG_VS = 1, SIG_BL = 2, SIG_COL = 3,
                 SIG_STB = 4, SIG_ACLK = 5, SIG_ERR = 6;

  typedef struct {
    string     tag;
    int        sel;
    logic [7:0] exp;
  } item_t;

  logic clk = 0;
  logic rstN = 0;
  logic takeSyncN = 1, takePixN = 1, takeClkN = 1;
  logic [2:0] clkSelCode = 3'b000;
  logic errClear = 0;
  logic ctlHsync = 0, ctlVsync = 0, ctlBlankN = 1, ctlDotStb = 0;
  logic adpHsync = 0, adpVsync = 0, adpBlankN = 1, adpDotStb = 0;
  logic [7:0] ctlPixel = '0, adpPixel = '0;
  logic outHsync, outVsync, outBlankN, dotStbOut, adpClkOut, cfgErr;
  logic [7:0] dacColor;

  int checks = 0, errors = 0;
  bit finished = 0;
  item_t q[$];

  always #5 clk = ~clk;

  vdac_src_sel u_dut (
    .clk(clk), .rstN(rstN), .takeSyncN(takeSyncN), .takePixN(takePixN),
    .takeClkN(takeClkN), .clkSelCode(clkSelCode), .errClear(errClear),
    .ctlHsync(ctlHsync), .ctlVsync(ctlVsync), .ctlBlankN(ctlBlankN),
    .ctlPixel(ctlPixel), .ctlDotStb(ctlDotStb),
    .adpHsync(adpHsync), .adpVsync(adpVsync), .adpBlankN(adpBlankN),
    .adpPixel(adpPixel), .adpDotStb(adpDotStb),
    .outHsync(outHsync), .outVsync(outVsync), .outBlankN(outBlankN),
    .dacColor(dacColor), .dotStbOut(dotStbOut), .adpClkOut(adpClkOut),
    .cfgErr(cfgErr)
  );

  function automatic logic [7:0] pick(int sel);
    case (sel)
      SIG_HS:   return {7'd0, outHsync};
      SIG_VS:   return {7'd0, outVsync};
      SIG_BL:   return {7'd0, outBlankN};
      SIG_COL:  return dacColor;
      SIG_STB:  return {7'd0, dotStbOut};
      SIG_ACLK: return {7'd0, adpClkOut};
      default:  return {7'd0, cfgErr};
    endcase
  endfunction

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = pick(it.sel);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sig%0d actual %h expected %h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic want(string tag, int sel, logic [7:0] e);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e;
    q.push_back(it);
  endtask

  task automatic adv(int k);
    repeat (k) @(posedge clk);
  endtask

  task automatic flush();
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #1;

    // Reset state
    adv(1);
    want("R9 reset cfgErr", SIG_ERR, 8'h00);
    want("R9 reset latch", SIG_COL, 8'h00);
    want("R9 reset blank", SIG_BL, 8'h01);
    flush();

    // Sync group
    ctlHsync = 1; ctlVsync = 0; adpHsync = 0; adpVsync = 1;
    adv(1);
    want("R1 ctl hsync", SIG_HS, 8'h01);
    want("R1 ctl vsync", SIG_VS, 8'h00);
    flush();
    takeSyncN = 0;
    adv(1);
    want("R9 one edge not yet", SIG_HS, 8'h01);
    flush();
    adv(1);
    want("R1 adp hsync", SIG_HS, 8'h00);
    want("R1 adp vsync", SIG_VS, 8'h01);
    flush();

    // Pixel capture, internal source
    ctlPixel = 8'h5A; ctlDotStb = 1;
    adv(1);
    want("R4 capture ctl", SIG_COL, 8'h5A);
    want("R3 forward strobe", SIG_ACLK, 8'h01);
    flush();
    ctlDotStb = 0; ctlPixel = 8'h33;
    adv(2);
    want("R4 hold", SIG_COL, 8'h5A);
    flush();
    takePixN = 0; adpPixel = 8'hC3;
    adv(2);
    flush();
    ctlDotStb = 1;
    adv(1);
    want("R2 adp pixel", SIG_COL, 8'hC3);
    flush();
    ctlDotStb = 0;

    // Unselected strobe ignored
    adpDotStb = 1; adpPixel = 8'h11;
    adv(1);
    want("R3 adp stb ignored", SIG_COL, 8'hC3);
    want("R3 dotStbOut int", SIG_STB, 8'h00);
    flush();
    adpDotStb = 0;

    // Switch to external clock: transient mismatch
    clkSelCode = 3'b010; takeClkN = 0;
    adv(3);
    want("R6 transient mismatch", SIG_ERR, 8'h01);
    flush();
    errClear = 1;
    adv(1);
    flush();
    errClear = 0;
    adv(1);
    want("R8 cleared", SIG_ERR, 8'h00);
    flush();

    ctlDotStb = 1; ctlPixel = 8'h77;
    adv(1);
    want("R3 ctl stb ignored", SIG_COL, 8'hC3);
    want("R3 no forward ext", SIG_ACLK, 8'h00);
    flush();
    ctlDotStb = 0; adpDotStb = 1; adpPixel = 8'h9E;
    adv(1);
    want("R3 adp capture", SIG_COL, 8'h9E);
    want("R3 dotStbOut ext", SIG_STB, 8'h01);
    flush();
    adpDotStb = 0;

    // Blanking with a capture inside
    adpBlankN = 0;
    adv(1);
    want("R5 blank zero", SIG_COL, 8'h00);
    want("R1 adp blank", SIG_BL, 8'h00);
    flush();
    adpDotStb = 1; adpPixel = 8'h44;
    adv(1);
    want("R5 blank during capture", SIG_COL, 8'h00);
    flush();
    adpDotStb = 0; adpBlankN = 1;
    adv(1);
    want("R5 unblank shows latch", SIG_COL, 8'h44);
    flush();

    // External clock without external pixel
    takePixN = 1;
    adv(3);
    want("R7 clk without pix", SIG_ERR, 8'h01);
    flush();
    takePixN = 0;
    adv(3);
    flush();
    errClear = 1;
    adv(1);
    flush();
    errClear = 0;
    adv(1);
    want("R8 cleared again", SIG_ERR, 8'h00);
    flush();

    // Set and clear in the same cycle
    clkSelCode = 3'b000; errClear = 1;
    adv(1);
    want("R8 set wins", SIG_ERR, 8'h01);
    flush();
    adv(1);
    flush();
    clkSelCode = 3'b010;
    adv(1);
    want("R8 clear after fix", SIG_ERR, 8'h00);
    flush();
    errClear = 0;

    // Sticky with wrong code
    clkSelCode = 3'b011;
    adv(1);
    want("R6 wrong code ext", SIG_ERR, 8'h01);
    flush();
    clkSelCode = 3'b010;
    adv(2);
    want("R8 sticky", SIG_ERR, 8'h01);
    flush();

    flush();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule